// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit unsigned operands and a carry-in and returns a 20-bit sum and a carry-out. It has no clock or state. The operand bits are split into five carry-select stages of growing length, with widths 2, 3, 4, 5 and 6. Every stage forms per-bit propagate and generate terms. The lowest stage ripples the true carry-in directly. Each higher stage ripples two carry vectors side by side: one assumes an incoming carry of 0 and the other assumes 1.

A small selection chain turns the true carry at each stage boundary into a pick strobe for that stage. The datapath then keeps the matching sum slice. The carry-out of the chosen variant becomes the carry into the next stage.

The widths grow by one bit per stage. Each stage therefore has one more bit of local ripple time than the stage below it, and that extra time matches the extra multiplexer the incoming carry has passed through. This makes the block suit an address or datapath adder where the carry path would otherwise limit the cycle time.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sumOut` equals the low 20 bits of `opA + opB + carryIn`, and `carryOut` equals bit 20 of that total, for any operand values.
- R2: A carry formed below a stage boundary (bit 2, 5, 9 or 14) reaches the bit above the boundary when every bit in between propagates. Example: 0x003+0x001 gives 0x004, and 0x3FFF+0x1 gives 0x4000.
- R3: When `opA ^ opB` is all ones, the result is 0xFFFFF with no carry-out for `carryIn`=0. For `carryIn`=1 the result is 0x00000 with `carryOut`=1.
- R4: A bit position where both operand bits are 0 stops the carry. With `opA`=0xFFFFC, `opB`=0 and `carryIn`=1, the result is 0xFFFFD and `carryOut` is 0.
- R5: `carryOut` is the carry selected out of the stage that covers bits 14-19. A generate at bit 14, with bits 15-19 propagating, gives `carryOut`=1 and a zero sum (0xFC000+0x04000).
- R6: Zero operands with `carryIn`=0 give a zero sum and no carry-out.
- R7: Operands of all ones with `carryIn`=1 give 0xFFFFF and `carryOut`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 20 | First addend |
| opB | input | 20 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 20 | Sum bits |
| carryOut | output | 1 | Carry out of bit 19 |

## Verification
Two functions can act on the same input vector: a stage's local carry generation, and the choice between its two precomputed variants made by the carry arriving from below. The bench provokes both at once with operands that generate in a low stage and then propagate across one or more boundaries, such as 0x3FFF+1 and the alternating 0xAAAAA+0x55555 pattern with each carry-in value. It judges each result against an arithmetic total computed independently in the bench, and against a table of hand-worked results.

// File: rtl/sqrt_csel_pkg.sv
package sqrt_csel_pkg;

  // number of carry-select stages and width of the lowest one
  localparam int STAGE_COUNT = 5;
  localparam int BASE_WIDTH  = 2;

  // stage s is BASE_WIDTH + s bits wide
  function automatic int stageWidth(input int baseW, input int s);
    return baseW + s;
  endfunction

  // lowest bit index covered by stage s
  function automatic int stageLow(input int baseW, input int s);
    return s * baseW + (s * (s - 1)) / 2;
  endfunction

  // total operand width for a given base width
  function automatic int totalWidth(input int baseW);
    return stageLow(baseW, STAGE_COUNT);
  endfunction

  // strobes from the selection chain to the datapath:
  // pickHigh[s] = 1 keeps the variant computed with an assumed carry-in of 1
  typedef struct packed {
    logic [STAGE_COUNT-1:0] pickHigh;
  } selStrobe_t;

endpackage

// File: rtl/csel_block.sv
module csel_block #(
  parameter int W    = 2,
  parameter bit DUAL = 1'b1
) (
  input  logic [W-1:0] blkA,
  input  logic [W-1:0] blkB,
  input  logic         cinTrue,
  output logic [W-1:0] sumLo,
  output logic [W-1:0] sumHi,
  output logic         coutLo,
  output logic         coutHi
);

  // setup: per-bit propagate and generate
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  assign prop = blkA ^ blkB;
  assign gen  = blkA & blkB;

  // carry vectors seen at each bit for both assumptions
  logic [W-1:0] carryVecLo;
  logic [W-1:0] carryVecHi;

  always_comb begin
    logic cLo;
    logic cHi;
    cLo = DUAL ? 1'b0 : cinTrue;
    cHi = DUAL ? 1'b1 : cinTrue;
    for (int i = 0; i < W; i++) begin
      carryVecLo[i] = cLo;
      carryVecHi[i] = cHi;
      cLo = gen[i] | (prop[i] & cLo);
      cHi = gen[i] | (prop[i] & cHi);
    end
    coutLo = cLo;
    coutHi = cHi;
    sumLo  = prop ^ carryVecLo;
    sumHi  = prop ^ carryVecHi;

    if (DUAL) begin
      // R1: the carry-in-1 variant is the carry-in-0 variant plus one
      a_r1_variant_step: assert ({coutHi, sumHi} == {coutLo, sumLo} + {{W{1'b0}}, 1'b1})
        else $error("variant results disagree");
      // R3: a fully propagating stage passes its assumed carry straight out
      if (&prop) begin
        a_r3_full_propagate: assert (coutLo == 1'b0 && coutHi == 1'b1)
          else $error("propagate stage mis-forwards carry");
      end
      // R4: a stage with no propagate bit makes its carry-out independent of its carry-in
      if (prop == '0) begin
        a_r4_no_propagate: assert (coutLo == coutHi)
          else $error("killed stage depends on carry-in");
      end
      // R1: the carry-in-1 variant never yields a smaller carry-out
      a_r1_monotone: assert (coutHi | ~coutLo)
        else $error("carry not monotone in carry-in");
    end
  end

endmodule

// File: rtl/sqrt_csel_datapath.sv
module sqrt_csel_datapath
  import sqrt_csel_pkg::*;
#(
  parameter int BASE_W = BASE_WIDTH,
  localparam int WIDTH = totalWidth(BASE_W)
) (
  input  logic [WIDTH-1:0]       opA,
  input  logic [WIDTH-1:0]       opB,
  input  logic                   carryIn,
  input  selStrobe_t             strobes,
  output logic [STAGE_COUNT-1:0] stageCoutLo,
  output logic [STAGE_COUNT-1:0] stageCoutHi,
  output logic [WIDTH-1:0]       sumOut
);

  for (genvar s = 0; s < STAGE_COUNT; s++) begin : g_stage
    localparam int LO = stageLow(BASE_W, s);
    localparam int SW = stageWidth(BASE_W, s);

    logic [SW-1:0] sumLo;
    logic [SW-1:0] sumHi;

    // the lowest stage ripples the real carry-in; the others precompute both cases
    csel_block #(
      .W    (SW),
      .DUAL (s != 0)
    ) u_blk (
      .blkA    (opA[LO +: SW]),
      .blkB    (opB[LO +: SW]),
      .cinTrue (s == 0 ? carryIn : 1'b0),
      .sumLo   (sumLo),
      .sumHi   (sumHi),
      .coutLo  (stageCoutLo[s]),
      .coutHi  (stageCoutHi[s])
    );

    assign sumOut[LO +: SW] = strobes.pickHigh[s] ? sumHi : sumLo;
  end

endmodule

// File: rtl/sqrt_csel_select.sv
module sqrt_csel_select
  import sqrt_csel_pkg::*;
(
  input  logic                   carryIn,
  input  logic [STAGE_COUNT-1:0] stageCoutLo,
  input  logic [STAGE_COUNT-1:0] stageCoutHi,
  output selStrobe_t             strobes,
  output logic                   carryOut
);

  // multiplexer chain: the true carry at each boundary picks the next stage's variant
  always_comb begin
    logic c;
    c = carryIn;
    for (int s = 0; s < STAGE_COUNT; s++) begin
      strobes.pickHigh[s] = c;
      c = c ? stageCoutHi[s] : stageCoutLo[s];
    end
    carryOut = c;

    // R5: when the top stage has the same carry-out for both cases, the output cannot depend on the select
    if (stageCoutLo[STAGE_COUNT-1] == stageCoutHi[STAGE_COUNT-1]) begin
      a_r5_top_agree: assert (carryOut == stageCoutLo[STAGE_COUNT-1])
        else $error("top carry mis-selected");
    end
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqrt_csel_pkg::*;
#(
  parameter int BASE_W = BASE_WIDTH,
  localparam int WIDTH = totalWidth(BASE_W)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  selStrobe_t             strobes;
  logic [STAGE_COUNT-1:0] stageCoutLo;
  logic [STAGE_COUNT-1:0] stageCoutHi;

  sqrt_csel_datapath #(
    .BASE_W (BASE_W)
  ) u_dp (
    .opA         (opA),
    .opB         (opB),
    .carryIn     (carryIn),
    .strobes     (strobes),
    .stageCoutLo (stageCoutLo),
    .stageCoutHi (stageCoutHi),
    .sumOut      (sumOut)
  );

  sqrt_csel_select u_sel (
    .carryIn     (carryIn),
    .stageCoutLo (stageCoutLo),
    .stageCoutHi (stageCoutHi),
    .strobes     (strobes),
    .carryOut    (carryOut)
  );

endmodule

// File: tb/sim_sqrt_csel_adder.sv
module sim_sqrt_csel_adder;

  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int NVEC = 12;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic carryOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqrt_csel_adder u0 (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  // {a, b, cin, expected carry, expected sum}
  localparam logic [61:0] VEC [NVEC] = '{
    {20'h00000, 20'h00000, 1'b0, 1'b0, 20'h00000},  // R6
    {20'hFFFFF, 20'h00000, 1'b1, 1'b1, 20'h00000},  // R3
    {20'hFFFFF, 20'hFFFFF, 1'b1, 1'b1, 20'hFFFFF},  // R7
    {20'h00003, 20'h00001, 1'b0, 1'b0, 20'h00004},  // R2 boundary at bit 2
    {20'h0001F, 20'h00001, 1'b0, 1'b0, 20'h00020},  // R2 boundary at bit 5
    {20'h001FF, 20'h00001, 1'b0, 1'b0, 20'h00200},  // R2 boundary at bit 9
    {20'h03FFF, 20'h00001, 1'b0, 1'b0, 20'h04000},  // R2 boundary at bit 14
    {20'hAAAAA, 20'h55555, 1'b1, 1'b1, 20'h00000},  // R3
    {20'hAAAAA, 20'h55555, 1'b0, 1'b0, 20'hFFFFF},  // R3
    {20'h12345, 20'h00001, 1'b0, 1'b0, 20'h12346},  // R1
    {20'h80000, 20'h80000, 1'b0, 1'b1, 20'h00000},  // R5
    {20'h7FFFF, 20'h00000, 1'b1, 1'b0, 20'h80000}   // R2
  };

  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic cin, input logic expC,
                            input logic [W-1:0] expS, input string tag);
    @(negedge clk);
    opA = a;
    opB = b;
    carryIn = cin;
    #1;
    checks++;
    if (sumOut !== expS || carryOut !== expC) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d got %0d:%h expected %0d:%h",
               tag, a, b, cin, carryOut, sumOut, expC, expS);
    end
  endtask

  task automatic checkRef(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic cin, input string tag);
    logic [W:0] total;
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    applyCheck(a, b, cin, total[W], total[W-1:0], tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    // reset state: zero inputs held, R6
    repeat (3) @(posedge clk);
    applyCheck('0, '0, 1'b0, 1'b0, '0, "R6 zero under reset");
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      applyCheck(VEC[i][61:42], VEC[i][41:22], VEC[i][21], VEC[i][20], VEC[i][19:0],
                 $sformatf("R1 table row %0d", i));
    end

    // R2: carry from bit 0 across every boundary at once
    applyCheck(20'h00001, 20'h00001, 1'b0, 1'b0, 20'h00002, "R2 generate in low stage");
    applyCheck(20'h0FFFF, 20'h00000, 1'b1, 1'b0, 20'h10000, "R2 carry-in across four boundaries");
    // R3: full propagate with each carry-in
    applyCheck(20'hF0F0F, 20'h0F0F0, 1'b0, 1'b0, 20'hFFFFF, "R3 propagate cin0");
    applyCheck(20'hF0F0F, 20'h0F0F0, 1'b1, 1'b1, 20'h00000, "R3 propagate cin1");
    // R4: killed at bit 1, the upper bits are unaffected by the carry-in
    applyCheck(20'hFFFFC, 20'h00000, 1'b1, 1'b0, 20'hFFFFD, "R4 kill at bit 1");
    applyCheck(20'hFFFFC, 20'h00000, 1'b0, 1'b0, 20'hFFFFC, "R4 kill reference");
    // R5: top stage generate-propagate
    applyCheck(20'hFC000, 20'h04000, 1'b0, 1'b1, 20'h00000, "R5 top stage carry");
    applyCheck(20'hFC000, 20'h03FFF, 1'b1, 1'b1, 20'h00000, "R5 carry from below into top stage");
    // R6, R7 corner values
    applyCheck(20'h00000, 20'h00000, 1'b1, 1'b0, 20'h00001, "R6 zero with carry-in");
    applyCheck(20'hFFFFF, 20'hFFFFF, 1'b0, 1'b1, 20'hFFFFE, "R7 max without carry-in");

    // R1: random operands against an arithmetic reference
    for (int i = 0; i < 400; i++) begin
      checkRef(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule